// File: doc/BRIEF.md
# Multi-format audio serial data port

This block moves PCM audio samples between a chip's system clock domain and a serial audio bus made of a bit clock, a word clock and one data line in each direction. The bit and word clocks arrive as inputs, whether they come from a local clock generator or from an external bus master. The block oversamples them with the system clock and works on their edges. The transmit side sends one mono sample, latched at the start of every frame, in both the left and the right slot. The receive side gathers the left and right samples from the data-in line and presents each one as a left-aligned 32-bit word with a single-cycle strobe.

Configuration inputs choose one of four framing modes (I2S, DSP/TDM with a pulse frame sync, right-justified, left-justified), a sample width, a start-of-data delay counted in bit clocks, the bit-clock edge used for launching and capturing, and whether the output driver is released on every bit clock outside the data window. The delay and the output release together let several devices share one TDM bus. Configuration is copied into internal shadow registers at reset and at each frame start. A change made part way through a frame therefore takes effect at the next frame.

Top module: `aud_serial_port`

## Requirements
- R1: With mode 2'b11 (left-justified), the left slot is the word-clock-high half. The right slot is the low half. The MSB of each slot is at bit clock `offset` counted from 0 at the first bit clock after the word-clock transition.
- R2: With mode 2'b00 (I2S), the left slot is the word-clock-low half. The right slot is the high half. The MSB comes one bit clock after the word-clock transition, plus `offset`.
- R3: With mode 2'b10 (right-justified), the LSB of each slot is the last bit clock before the next word-clock transition. The slot length is measured from the previous half-frame, and `offset` is ignored.
- R4: With mode 2'b01 (DSP/TDM), a rising word clock starts the frame. The left MSB is at bit clock `offset` counted from 0 at the pulse bit. The right slot follows the left slot immediately.
- R5: The width field selects 16 (2'b00), 20 (2'b01), 24 (2'b10) or 32 (2'b11) bits. A received word holds its bits from bit 31 downward, and the unused low bits are zero.
- R6: Both directions carry the most significant bit first. Transmit bit k of a slot is `tx_sample[31-k]`.
- R7: The programmed offset delays the first data bit by exactly that many bit clocks.
- R8: With invert clear, data is launched on the falling bit-clock edge and captured on the rising edge. With invert set, the two edges swap, in every mode.
- R9: With tri-state enabled, `dout_oe` is low on every bit clock outside a data slot. With it disabled, `dout_oe` stays high and `dout` is 0 outside a slot.
- R10: `tx_sample` is latched at each frame start and sent in both the left and the right slot.
- R11: Each received sample raises `rx_valid` for one system clock. `rx_right` is 1 for the right slot and 0 for the left slot.
- R12: Mode, width, offset, invert and tri-state are loaded at reset and at frame starts only. A change in mid-frame does not alter the frame in progress.
- R13: Between reset and the first frame start, no data is sent and no sample is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| wclk | input | 1 | Serial word clock / frame sync |
| din | input | 1 | Serial data in |
| cfg_mode | input | 2 | Framing mode: 00 I2S, 01 DSP/TDM, 10 right-justified, 11 left-justified |
| cfg_width | input | 2 | Sample width code: 16/20/24/32 bits |
| cfg_offset | input | OFS_W | Start-of-data delay in bit clocks |
| cfg_bclk_inv | input | 1 | Swap launch and capture bit-clock edges |
| cfg_tristate | input | 1 | Release the output driver outside data slots |
| tx_sample | input | 32 | Mono sample to send, left-aligned |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for the data-out pad |
| rx_data | output | 32 | Received sample, left-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_right | output | 1 | Channel of rx_data: 1 right, 0 left |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a frame. It must leave the running frame alone and only shape the following one. The bench changes the width input partway through a left slot. It then expects the old width for the rest of that frame and the new width in the next frame, on both data lines. Right-justified framing needs a half-frame length measured beforehand, so every run begins after reset with a full-length idle half at the right-channel level. The bench checks during that idle stretch that nothing leaves the block.

// File: rtl/aud_serial_port.sv
module aud_serial_port #(
  parameter int OFS_W = 8,
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             wclk,
  input  logic             din,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_width,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic             cfg_bclk_inv,
  input  logic             cfg_tristate,
  input  logic [31:0]      tx_sample,
  output logic             dout,
  output logic             dout_oe,
  output logic [31:0]      rx_data,
  output logic             rx_valid,
  output logic             rx_right
);
  localparam logic [1:0] MD_I2S = 2'b00;
  localparam logic [1:0] MD_DSP = 2'b01;
  localparam logic [1:0] MD_RJ  = 2'b10;

  logic             bclk_s, bclk_d, wclk_s, din_s, wclk_q;
  logic [1:0]       mode_q, width_q;
  logic [OFS_W-1:0] ofs_q;
  logic             inv_q, tri_q, locked_q, right_q;
  logic [POS_W-1:0] pos, halflen;
  logic [31:0]      tx_hold, rx_sh, rx_next;

  logic rise, fall, launch, capture, is_dsp, wchg, frame_start, half_edge;
  logic dsp_right, chan, rj_ok, in_slot;
  logic [POS_W:0] wbits, posx, ofsx, start;
  logic [4:0]     k;

  assign rise    = bclk_s & ~bclk_d;
  assign fall    = ~bclk_s & bclk_d;
  assign launch  = inv_q ? rise : fall;
  assign capture = inv_q ? fall : rise;

  assign is_dsp      = (mode_q == MD_DSP);
  assign wchg        = wclk_s ^ wclk_q;
  assign frame_start = is_dsp ? (wclk_s & ~wclk_q) : (wchg & (wclk_s == (mode_q != MD_I2S)));
  assign half_edge   = is_dsp ? frame_start : wchg;

  always_comb begin
    case (width_q)
      2'b00:   wbits = (POS_W+1)'(16);
      2'b01:   wbits = (POS_W+1)'(20);
      2'b10:   wbits = (POS_W+1)'(24);
      default: wbits = (POS_W+1)'(32);
    endcase
  end

  assign posx      = {1'b0, pos};
  assign ofsx      = (POS_W+1)'(ofs_q);
  assign dsp_right = posx >= ofsx + wbits;
  assign chan      = is_dsp ? dsp_right : right_q;
  assign rj_ok     = (mode_q != MD_RJ) || ({1'b0, halflen} >= wbits);

  always_comb begin
    case (mode_q)
      MD_I2S:  start = ofsx + 1'b1;
      MD_DSP:  start = dsp_right ? ofsx + wbits : ofsx;
      MD_RJ:   start = {1'b0, halflen} - wbits;
      default: start = ofsx;
    endcase
  end

  assign in_slot = locked_q && rj_ok && (posx >= start) && (posx < start + wbits);
  assign k       = 5'(posx - start);
  assign dout    = in_slot & tx_hold[5'd31 - k];
  assign dout_oe = in_slot | ~tri_q;

  always_comb begin
    rx_next = (k == 5'd0) ? 32'd0 : rx_sh;
    rx_next[5'd31 - k] = din_s;
  end

  always_ff @(posedge clk) begin
    bclk_s   <= bclk;
    bclk_d   <= bclk_s;
    wclk_s   <= wclk;
    din_s    <= din;
    rx_valid <= 1'b0;
    if (!rst_n) begin
      mode_q   <= cfg_mode;
      width_q  <= cfg_width;
      ofs_q    <= cfg_offset;
      inv_q    <= cfg_bclk_inv;
      tri_q    <= cfg_tristate;
      wclk_q   <= 1'b0;
      pos      <= '1;
      halflen  <= '0;
      right_q  <= 1'b0;
      locked_q <= 1'b0;
      tx_hold  <= '0;
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_right <= 1'b0;
    end else begin
      if (launch) begin
        wclk_q <= wclk_s;
        if (half_edge) begin
          pos <= '0;
          if (!is_dsp) begin
            halflen <= pos + 1'b1;
            right_q <= (wclk_s == (mode_q == MD_I2S));
          end
        end else begin
          pos <= pos + 1'b1;
        end
        if (frame_start) begin
          locked_q <= 1'b1;
          tx_hold  <= tx_sample;
          mode_q   <= cfg_mode;
          width_q  <= cfg_width;
          ofs_q    <= cfg_offset;
          inv_q    <= cfg_bclk_inv;
          tri_q    <= cfg_tristate;
        end
      end
      if (capture && in_slot) begin
        rx_sh <= rx_next;
        if ((POS_W+1)'(k) == wbits - 1'b1) begin
          rx_data  <= rx_next;
          rx_valid <= 1'b1;
          rx_right <= chan;
        end
      end
    end
  end
endmodule

// File: rtl/aud_serial_port_chk.sv
module aud_serial_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        launch,
  input logic        capture,
  input logic        locked_q,
  input logic        dout,
  input logic        dout_oe,
  input logic        rx_valid,
  input logic [15:0] rx_low,
  input logic [1:0]  width_q
);
  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);                                            // R11
  AST_RX_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(capture));                                       // R8
  AST_OUT_HOLDS_OFF_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> ($stable(dout) && $stable(dout_oe)));                   // R8
  AST_NO_TX_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> !dout);                                               // R13
  AST_NO_RX_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> locked_q);                                             // R13
  AST_NARROW_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && width_q == 2'b00) |-> (rx_low == 16'd0));              // R5
endmodule

bind aud_serial_port aud_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .capture(capture),
  .locked_q(locked_q), .dout(dout), .dout_oe(dout_oe), .rx_valid(rx_valid),
  .rx_low(rx_data[15:0]), .width_q(width_q)
);

// File: tb/aud_serial_port_tb.sv
module aud_serial_port_tb;
  localparam int HL = 40;
  localparam int FL = 80;
  localparam logic [1:0] MD_I2S = 2'b00, MD_DSP = 2'b01, MD_RJ = 2'b10, MD_LJ = 2'b11;

  logic clk = 0, rst_n = 0, bclk = 1, wclk = 0, din = 0;
  logic [1:0] cfg_mode = MD_I2S, cfg_width = 2'b00;
  logic [7:0] cfg_offset = 0;
  logic cfg_bclk_inv = 0, cfg_tristate = 0;
  logic [31:0] tx_sample = 0;
  logic dout, dout_oe, rx_valid, rx_right;
  logic [31:0] rx_data;

  int n_chk = 0, n_fail = 0;
  int chg_at = -1;
  logic [1:0] chg_w = 2'b00;
  logic [32:0] sb_q[$];
  bit finished = 0;

  always #2 clk = ~clk;

  aud_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .din(din),
    .cfg_mode(cfg_mode), .cfg_width(cfg_width), .cfg_offset(cfg_offset),
    .cfg_bclk_inv(cfg_bclk_inv), .cfg_tristate(cfg_tristate), .tx_sample(tx_sample),
    .dout(dout), .dout_oe(dout_oe), .rx_data(rx_data), .rx_valid(rx_valid), .rx_right(rx_right)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] c);
    case (c) 2'b00: return 16; 2'b01: return 20; 2'b10: return 24; default: return 32; endcase
  endfunction

  function automatic int start_of(input logic [1:0] m, input int w, input int o, input bit rgt);
    case (m)
      MD_I2S:  return o + 1;
      MD_DSP:  return o + (rgt ? w : 0);
      MD_RJ:   return HL - w;
      default: return o;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (sb_q.size() == 0) begin
        check(0, "R13", "sample with nothing expected", {31'd0, rx_right, rx_data}, 64'd0);
      end else begin
        logic [32:0] e;
        e = sb_q.pop_front();
        check({rx_right, rx_data} == e, "R11/R6", "received sample",
              {31'd0, rx_right, rx_data}, {31'd0, e});
      end
    end
  end

  task automatic one_bit(input logic wv, input logic dv, output logic ad, output logic ao);
    bclk = cfg_bclk_inv; wclk = wv; din = dv;
    repeat (4) @(negedge clk);
    ad = dout; ao = dout_oe;
    bclk = ~cfg_bclk_inv;
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] w, input int o,
                       input bit inv, input bit tri_en);
    int nb, nerr;
    logic ad, ao;
    cfg_mode = m; cfg_width = w; cfg_offset = 8'(o); cfg_bclk_inv = inv; cfg_tristate = tri_en;
    bclk = ~inv; tx_sample = 32'hFFFF_FFFF;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    nb = (m == MD_DSP) ? 8 : HL;
    nerr = 0;
    for (int i = 0; i < nb; i++) begin
      one_bit((m == MD_I2S), 1'(i), ad, ao);
      if (ad !== 1'b0 || ao !== !tri_en) nerr++;
    end
    check(nerr == 0, "R13", "idle output before first frame", {63'd0, ao}, {63'd0, !tri_en});
  endtask

  task automatic run_frame(input logic [31:0] txs, input logic [31:0] ls, input logic [31:0] rs,
                           input string tag);
    logic [1:0] m;
    int w, o, n, nerr;
    bit t;
    logic [31:0] msk;
    logic fad, fao, fed, feo;
    m = cfg_mode; w = wbits(cfg_width); o = int'(cfg_offset); t = cfg_tristate;
    msk = 32'hFFFF_FFFF << (32 - w);
    tx_sample = txs;
    sb_q.push_back({1'b0, ls & msk});
    sb_q.push_back({1'b1, rs & msk});
    n = (m == MD_DSP) ? FL : 2 * HL;
    nerr = 0; fad = 0; fao = 0; fed = 0; feo = 0;
    for (int i = 0; i < n; i++) begin
      bit rgt, ins;
      int p, s;
      logic wv, dv, ad, ao, ed, eo;
      logic [31:0] smp;
      if (m == MD_DSP) begin
        p = i; rgt = (i >= o + w); wv = (i == 0);
      end else begin
        rgt = (i >= HL); p = rgt ? i - HL : i; wv = rgt ^ (m != MD_I2S);
      end
      s = start_of(m, w, o, rgt);
      smp = rgt ? rs : ls;
      ins = (p >= s) && (p < s + w);
      dv = ins ? smp[31 - (p - s)] : ~1'(p);
      if (chg_at == i) cfg_width = chg_w;
      one_bit(wv, dv, ad, ao);
      ed = ins ? txs[31 - (p - s)] : 1'b0;
      eo = ins || !t;
      if (ad !== ed || ao !== eo) begin
        if (nerr == 0) begin fad = ad; fao = ao; fed = ed; feo = eo; end
        nerr++;
      end
    end
    check(nerr == 0, tag, "transmit bits {dout,oe}", {62'd0, fad, fao}, {62'd0, fed, feo});
  endtask

  task automatic drain(input string tag);
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, tag, "samples outstanding", 64'(sb_q.size()), 64'd0);
    sb_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rx_valid == 1'b0 && dout == 1'b0, "R13", "reset state", {62'd0, rx_valid, dout}, 64'd0);

    // R2 R5 R10: I2S, 16 bit, no offset, driver always on
    setup(MD_I2S, 2'b00, 0, 0, 0);
    run_frame(32'hA5C3_1234, 32'h8001_FFFF, 32'h7FFE_0001, "R2");
    run_frame(32'h0F0F_F0F0, 32'hDEAD_BEEF, 32'h1234_5678, "R10");
    drain("R2");

    // R1 R7 R9: left-justified, 24 bit, offset 3, tri-state
    setup(MD_LJ, 2'b10, 3, 0, 1);
    run_frame(32'hC0FF_EE11, 32'hFEDC_BA98, 32'h0123_4567, "R7");
    run_frame(32'h5555_AAAA, 32'h8000_0001, 32'hFFFF_FF00, "R9");
    drain("R1");

    // R3: right-justified, 20 bit, offset ignored
    setup(MD_RJ, 2'b01, 5, 0, 1);
    run_frame(32'h9ABC_DEF0, 32'hF000_F000, 32'h0FFF_F000, "R3");
    run_frame(32'h1357_9BDF, 32'hABCD_E000, 32'h5432_1000, "R3");
    drain("R3");

    // R4 R5: DSP, 32 bit, offset 2
    setup(MD_DSP, 2'b11, 2, 0, 1);
    run_frame(32'h8765_4321, 32'hCAFE_F00D, 32'h0BAD_CAFE, "R4");
    run_frame(32'hFFFF_0000, 32'h0000_0001, 32'h8000_0000, "R5");
    drain("R4");

    // R8: I2S with swapped bit-clock edges, 32 bit, offset 7
    setup(MD_I2S, 2'b11, 7, 1, 0);
    run_frame(32'h2468_ACE0, 32'h1111_2222, 32'hEEEE_DDDD, "R8");
    run_frame(32'hB00B_1E55, 32'h7654_3210, 32'h89AB_CDEF, "R8");
    drain("R8");

    // R12: width change in mid-frame applies from the next frame
    setup(MD_LJ, 2'b00, 1, 0, 1);
    run_frame(32'hAAAA_5555, 32'h1234_ABCD, 32'h4321_DCBA, "R12");
    chg_at = 10; chg_w = 2'b11;
    run_frame(32'h5A5A_A5A5, 32'hF00F_0FF0, 32'h0FF0_F00F, "R12");
    chg_at = -1;
    run_frame(32'h3C3C_C3C3, 32'h8765_4321, 32'hFEDC_BA98, "R12");
    drain("R12");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule